// File: doc/BRIEF.md
# Lookup-Table Ripple Subtractor

This block forms the unsigned difference of two 4-bit operands, minuend minus subtrahend, without any adder gates. The arithmetic sits in four identical read-only cells. Each cell holds the eight two-bit words of a one-bit full adder. Each cell takes three address inputs and returns a carry bit and a sum bit. The cells are wired in a ripple chain. Each subtrahend bit is inverted before it reaches its cell. The carry into the lowest cell is held at 1, so the chain adds the minuend to the two's complement of the subtrahend.

The block is purely combinational. The difference wraps modulo 16. The carry out of the top cell is presented as a no-borrow flag. It reads 1 when the minuend is at least as large as the subtrahend, and 0 when the subtraction had to borrow.

Top module: `rom_subtractor`

## Requirements
- R1: Each cell is an 8-word by 2-bit constant table. Its address is {Z,Y,X}, with X on address bit 0 and Z on address bit 2. Word bit 0 is the carry-out and word bit 1 is the sum. The words for addresses 0 through 7 are 0, 2, 2, 1, 2, 1, 1, 3.
- R2: `diff` equals (`minuend` - `subtrahend`) modulo 16 for every one of the 256 operand pairs.
- R3: `no_borrow` is 1 exactly when `minuend` >= `subtrahend` as unsigned values, and 0 otherwise.
- R4: When both operands are equal, `diff` is 0 and `no_borrow` is 1.
- R5: When `subtrahend` is 0, `diff` equals `minuend` and `no_borrow` is 1.
- R6: When `minuend` is 0 and `subtrahend` is nonzero, `diff` equals 16 - `subtrahend` and `no_borrow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| minuend | input | 4 | Operand the other is taken from |
| subtrahend | input | 4 | Operand that is subtracted |
| diff | output | 4 | Difference modulo 16 |
| no_borrow | output | 1 | Final carry: 1 when no borrow occurred |

## Verification
The wrapped difference and the borrow flag come out of the same ripple evaluation, so every input pair settles both of them together. The sharpest cases are the pairs where the subtrahend exceeds the minuend: the difference wraps at the same moment the flag drops. These pairs are driven from a vector table and then from an exhaustive sweep, and each pair checks both outputs against an unsigned subtraction worked out separately in the bench. The lookup cell is also probed on its own at all eight addresses, so that a single bad table word is traced to the table itself and not only to a chain result.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
  localparam int CELL_ADDR_W = 3;
  localparam int CELL_DATA_W = 2;
  localparam int CARRY_BIT   = 0;
  localparam int SUM_BIT     = 1;
  localparam int CELL_DEPTH  = 1 << CELL_ADDR_W;

  // Full-adder word for one table address {z,y,x}
  function automatic logic [CELL_DATA_W-1:0] fa_word(input logic [CELL_ADDR_W-1:0] a);
    logic [CELL_DATA_W-1:0] w;
    w = '0;
    w[SUM_BIT]   = ^a;
    w[CARRY_BIT] = (a[0] & a[1]) | (a[0] & a[2]) | (a[1] & a[2]);
    return w;
  endfunction

  // Number of set address bits, used by the guard checks
  function automatic int unsigned ones3(input logic [CELL_ADDR_W-1:0] a);
    return int'(a[0]) + int'(a[1]) + int'(a[2]);
  endfunction
endpackage

// File: rtl/fa_lut_cell.sv
module fa_lut_cell
  import rsub_pkg::*;
(
  input  logic x_in,
  input  logic y_in,
  input  logic z_in,
  output logic carry_o,
  output logic sum_o
);
  logic [CELL_DATA_W-1:0] table_mem [CELL_DEPTH];
  logic [CELL_ADDR_W-1:0] addr;
  logic [CELL_DATA_W-1:0] word;

  for (genvar a = 0; a < CELL_DEPTH; a++) begin : g_word
    assign table_mem[a] = fa_word(CELL_ADDR_W'(a));
  end

  assign addr    = {z_in, y_in, x_in};
  assign word    = table_mem[addr];
  assign carry_o = word[CARRY_BIT];
  assign sum_o   = word[SUM_BIT];

  always_comb begin
    AST_CELL_SUM: assert (sum_o == ((ones3(addr) % 2) == 1)) else $error("cell sum wrong"); // R1
    AST_CELL_CARRY: assert (carry_o == (ones3(addr) >= 2)) else $error("cell carry wrong"); // R1
  end
endmodule

// File: rtl/operand_inverter.sv
module operand_inverter #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] inv_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_inv
    assign inv_o[i] = ~raw_i[i];
  end
endmodule

// File: rtl/rom_subtractor.sv
module rom_subtractor #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] minuend,
  input  logic [WIDTH-1:0] subtrahend,
  output logic [WIDTH-1:0] diff,
  output logic             no_borrow
);
  localparam int CHAIN_LEN = WIDTH + 1;

  logic [WIDTH-1:0]     sub_inv;
  logic [CHAIN_LEN-1:0] carry_chain;

  operand_inverter #(.WIDTH(WIDTH)) u_inv (
    .raw_i (subtrahend),
    .inv_o (sub_inv)
  );

  assign carry_chain[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    fa_lut_cell u_cell (
      .x_in    (minuend[i]),
      .y_in    (sub_inv[i]),
      .z_in    (carry_chain[i]),
      .carry_o (carry_chain[i+1]),
      .sum_o   (diff[i])
    );
  end

  assign no_borrow = carry_chain[WIDTH];

  always_comb begin
    AST_DIFF_WRAP: assert (diff == WIDTH'(minuend - subtrahend)) else $error("difference wrong"); // R2
    AST_NO_BORROW: assert (no_borrow == (minuend >= subtrahend)) else $error("borrow flag wrong"); // R3
    AST_EQUAL_ZERO: assert (!(minuend == subtrahend) || (diff == '0 && no_borrow)) else $error("equal operands"); // R4
    AST_ZERO_SUB: assert (!(subtrahend == '0) || (diff == minuend && no_borrow)) else $error("zero subtrahend"); // R5
  end
endmodule

// File: tb/tb_rom_subtractor.sv
module tb_rom_subtractor;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] minuend, subtrahend, diff;
  logic       no_borrow;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rom_subtractor dut (
    .minuend(minuend), .subtrahend(subtrahend), .diff(diff), .no_borrow(no_borrow)
  );

  logic px, py, pz, pc, ps;
  fa_lut_cell cell_probe (.x_in(px), .y_in(py), .z_in(pz), .carry_o(pc), .sum_o(ps));

  // {minuend, subtrahend, diff, no_borrow}
  localparam logic [12:0] VEC [12] = '{
    {4'd9,  4'd3,  4'd6,  1'b1},
    {4'd3,  4'd9,  4'd10, 1'b0},
    {4'd0,  4'd0,  4'd0,  1'b1},
    {4'd15, 4'd15, 4'd0,  1'b1},
    {4'd15, 4'd0,  4'd15, 1'b1},
    {4'd0,  4'd15, 4'd1,  1'b0},
    {4'd0,  4'd1,  4'd15, 1'b0},
    {4'd8,  4'd7,  4'd1,  1'b1},
    {4'd7,  4'd8,  4'd15, 1'b0},
    {4'd5,  4'd5,  4'd0,  1'b1},
    {4'd12, 4'd0,  4'd12, 1'b1},
    {4'd1,  4'd14, 4'd3,  1'b0}
  };

  // Expected cell words by address 0..7
  localparam logic [1:0] CELL_EXP [8] = '{2'd0, 2'd2, 2'd2, 2'd1, 2'd2, 2'd1, 2'd1, 2'd3};

  task automatic apply(input logic [3:0] m, input logic [3:0] s);
    @(posedge clk);
    #2;
    minuend = m;
    subtrahend = s;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: m=%0d s=%0d actual {nb,diff}=%b expected %b", tag, minuend, subtrahend, act, exp);
    end
  endtask

  initial begin
    minuend = '0; subtrahend = '0; px = 0; py = 0; pz = 0;

    // R1: the lookup cell at every address
    for (int a = 0; a < 8; a++) begin
      @(posedge clk); #2;
      {pz, py, px} = 3'(a);
      @(negedge clk);
      checks++;
      if ({ps, pc} !== CELL_EXP[a]) begin
        fails++;
        $display("FAIL R1: addr=%0d actual %b expected %b", a, {ps, pc}, CELL_EXP[a]);
      end
    end

    // R2/R3 vector table
    for (int v = 0; v < 12; v++) begin
      apply(VEC[v][12:9], VEC[v][8:5]);
      check("R2/R3 vector", {no_borrow, diff}, {VEC[v][0], VEC[v][4:1]});
    end

    // R2 and R3 exhaustive, expected from plain unsigned arithmetic
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        int e;
        e = (m >= s) ? (m - s) : (m + 16 - s);
        apply(4'(m), 4'(s));
        check("R2 diff", {1'b0, diff}, {1'b0, 4'(e)});
        check("R3 no_borrow", {no_borrow, 4'd0}, {(m >= s), 4'd0});
      end
    end

    // R4 equal operands
    for (int k = 0; k < 16; k++) begin
      apply(4'(k), 4'(k));
      check("R4 equal", {no_borrow, diff}, {1'b1, 4'd0});
    end

    // R5 zero subtrahend
    for (int k = 0; k < 16; k++) begin
      apply(4'(k), 4'd0);
      check("R5 zero subtrahend", {no_borrow, diff}, {1'b1, 4'(k)});
    end

    // R6 zero minuend
    for (int k = 1; k < 16; k++) begin
      apply(4'd0, 4'(k));
      check("R6 zero minuend", {no_borrow, diff}, {1'b0, 4'(16 - k)});
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule